// File: doc/BRIEF.md
# Connection Memory Block Initialiser

This block fills an entire connection memory in one hardware sweep so that software does not have to write every entry itself. Software first sets a mode-enable bit, which arms the fill, and then raises a one-cycle trigger. On the first trigger accepted while armed, the block captures a 4-bit pattern from the control register. It then writes every location, from address 0 to the last one, with the pattern in the top four bits and zeros in the twelve bits below.

The connection memory has one write port, and that port is shared with the per-channel read path of the switch. In any cycle where the read path owns the memory, the sweep does not write. It writes in the next free slot instead. While a sweep is running, the block owns the port outright and discards processor writes. When the sweep is idle, processor writes go straight through to the memory.

The trigger bit stays set for as long as the sweep runs and reads back as the busy flag. The hardware clears it after the last location is written. Software can also abort a sweep by clearing the mode enable.

Top module: `cm_block_fill`

## Requirements
- R1: After a synchronous active-low reset, `fill_busy` is 0 and `mem_we` is 0 while no processor write is presented.
- R2: A trigger pulse (`trig_set`=1) is ignored while `mode_en` is 0: `fill_busy` stays 0 and only processor writes reach the memory.
- R3: A trigger accepted at a clock edge while `mode_en`=1 and the block is idle sets `fill_busy` from the next cycle. The first fill write is to address 0 in the first free slot from that cycle on. A trigger that arrives while busy has no effect.
- R4: During a sweep, the fill writes addresses 0, 1, 2 … DEPTH-1 in ascending order, one address per cycle in which `rd_slot`=0.
- R5: Every fill write carries `mem_wdata[15:12]` equal to `fill_pat` as sampled at the edge that accepted the trigger, and `mem_wdata[11:0]`=0. Later changes to `fill_pat` do not alter a running sweep.
- R6: The cycle after the write to address DEPTH-1, `fill_busy` returns to 0. This clears the trigger without software action.
- R7: No write of any kind is issued in a cycle with `rd_slot`=1.
- R8: While `fill_busy`=1, processor writes (`cpu_wr`) are ignored and never reach the memory port.
- R9: While idle, a processor write in a cycle with `rd_slot`=0 is passed to the memory with its own address and data.
- R10: Driving `mode_en` to 0 during a sweep stops fill writes in that cycle and clears `fill_busy` at the next edge. A later trigger restarts the sweep at address 0.
- R11: With at most every other cycle taken by the read path, a sweep completes within two frames of FRAME_CYCLES clock cycles each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_en | input | 1 | Control-register bit that arms block filling |
| trig_set | input | 1 | One-cycle pulse from a control-register write setting the trigger bit |
| fill_pat | input | 4 | Control-register field holding the upper-nibble fill pattern |
| rd_slot | input | 1 | Read path owns the memory port this cycle |
| cpu_wr | input | 1 | Processor write request to connection memory |
| cpu_addr | input | $clog2(DEPTH) | Processor write address |
| cpu_wdata | input | 16 | Processor write data |
| mem_we | output | 1 | Connection memory write enable |
| mem_addr | output | $clog2(DEPTH) | Connection memory write address |
| mem_wdata | output | 16 | Connection memory write data |
| fill_busy | output | 1 | Trigger bit readback: high while a sweep runs |

## Verification
Three sweep patterns are used, and each tells a different part of the schedule apart:
- A sweep with no read slots shows the bare one-address-per-cycle order and the point where the trigger self-clears.
- A sweep with strictly alternating read slots is the worst case for the two-frame limit. It also checks that writes yield to the read path.
- A sweep with read slots on every third cycle catches address counters that advance on time rather than on actual writes.

Processor writes are mixed into a running sweep and into idle periods, which separates discard from pass-through. The captured fill pattern is changed mid-sweep, so a design that uses the live pattern instead of the captured one would write the wrong upper nibble. An abort followed by a fresh trigger shows that the address restarts at 0 rather than resuming.

// File: rtl/cmi_pkg.sv
`timescale 1ns/1ps
// Shared widths and state encoding for the connection memory initialiser.
package cmi_pkg;
    parameter int unsigned CM_W  = 16;            // connection memory word width
    parameter int unsigned PAT_W = 4;             // fill pattern width (upper field)
    localparam int unsigned LOW_W = CM_W - PAT_W; // zeroed lower field

    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_RUN  = 1'b1
    } fill_state_e;
endpackage

// File: rtl/cmi_trigger.sv
`timescale 1ns/1ps
// cmi_trigger: holds the self-clearing trigger bit and the captured pattern.
// Assumes trig_set is a single-cycle pulse produced by a register write.
// A trigger is accepted only while armed and idle. Loss of the arm bit
// aborts a sweep at the next edge.
module cmi_trigger
    import cmi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_en,
    input  logic             trig_set,
    input  logic [PAT_W-1:0] pat_in,
    input  logic             sweep_done,
    output logic             running,
    output logic [PAT_W-1:0] pat_q
);
    fill_state_e state_q;

    // Trigger state: arm/abort, start on trigger, self-clear on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FILL_IDLE;
        end else if (!mode_en) begin
            state_q <= FILL_IDLE;
        end else begin
            case (state_q)
                FILL_IDLE: if (trig_set)   state_q <= FILL_RUN;
                FILL_RUN:  if (sweep_done) state_q <= FILL_IDLE;
                default:                   state_q <= FILL_IDLE;
            endcase
        end
    end

    // Pattern capture at the edge that accepts the trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_q <= '0;
        end else if (mode_en && trig_set && state_q == FILL_IDLE) begin
            pat_q <= pat_in;
        end
    end

    assign running = (state_q == FILL_RUN);
endmodule

// File: rtl/cmi_sweep.sv
`timescale 1ns/1ps
// cmi_sweep: address generator for the fill. Held at 0 while idle, it
// advances by one on each cycle in which a fill write is issued.
// Assumes DEPTH >= 2. The wrap logic is picked by whether DEPTH is a power of two.
module cmi_sweep #(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          running,
    input  logic          advance,
    output logic [AW-1:0] addr,
    output logic          last
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    logic [AW-1:0] next_addr;

    generate
        if ((1 << AW) == DEPTH) begin : g_pow2
            // Natural binary wrap covers the last address.
            assign next_addr = addr + 1'b1;
        end else begin : g_npow2
            // Explicit wrap for a depth that is not a power of two.
            assign next_addr = (addr == LAST_ADDR) ? '0 : addr + 1'b1;
        end
    endgenerate

    // Address register: reset while idle, step on each fill write.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) begin
            addr <= '0;
        end else if (advance) begin
            addr <= next_addr;
        end
    end

    assign last = (addr == LAST_ADDR);
endmodule

// File: rtl/cmi_portmux.sv
`timescale 1ns/1ps
// cmi_portmux: drives the single connection memory write port.
// While a sweep runs, the fill owns the port and processor writes are dropped.
// While idle, processor writes pass through. A read slot blocks every write.
module cmi_portmux
    import cmi_pkg::*;
#(
    parameter int unsigned AW = 10
) (
    input  logic             running,
    input  logic             fill_wr,
    input  logic [AW-1:0]    fill_addr,
    input  logic [PAT_W-1:0] pat,
    input  logic             rd_slot,
    input  logic             cpu_wr,
    input  logic [AW-1:0]    cpu_addr,
    input  logic [CM_W-1:0]  cpu_wdata,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [CM_W-1:0]  mem_wdata
);
    // Port selection between fill and processor.
    always_comb begin
        if (running) begin
            mem_we    = fill_wr;
            mem_addr  = fill_addr;
            mem_wdata = {pat, {LOW_W{1'b0}}};
        end else begin
            mem_we    = cpu_wr && !rd_slot;
            mem_addr  = cpu_addr;
            mem_wdata = cpu_wdata;
        end
    end
endmodule

// File: rtl/cm_block_fill.sv
`timescale 1ns/1ps
// cm_block_fill: sweeps the whole connection memory, writing the captured
// pattern into the upper nibble and zeros below. It yields to the read path
// in read slots and self-clears its trigger bit when the sweep completes.
// Assumes the read path never needs more than every other cycle.
module cm_block_fill
    import cmi_pkg::*;
#(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_en,
    input  logic             trig_set,
    input  logic [PAT_W-1:0] fill_pat,
    input  logic             rd_slot,
    input  logic             cpu_wr,
    input  logic [AW-1:0]    cpu_addr,
    input  logic [CM_W-1:0]  cpu_wdata,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [CM_W-1:0]  mem_wdata,
    output logic             fill_busy
);
    logic             running;
    logic [PAT_W-1:0] pat_q;
    logic [AW-1:0]    fill_addr;
    logic             fill_last;
    logic             fill_wr;
    logic             sweep_done;

    // A fill write happens in every free slot while armed and running.
    assign fill_wr    = running && mode_en && !rd_slot;
    assign sweep_done = fill_wr && fill_last;
    assign fill_busy  = running;

    cmi_trigger i_trigger (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_en    (mode_en),
        .trig_set   (trig_set),
        .pat_in     (fill_pat),
        .sweep_done (sweep_done),
        .running    (running),
        .pat_q      (pat_q)
    );

    cmi_sweep #(.DEPTH(DEPTH)) i_sweep (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .advance (fill_wr),
        .addr    (fill_addr),
        .last    (fill_last)
    );

    cmi_portmux #(.AW(AW)) i_portmux (
        .running   (running),
        .fill_wr   (fill_wr),
        .fill_addr (fill_addr),
        .pat       (pat_q),
        .rd_slot   (rd_slot),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );
endmodule

// File: rtl/cm_block_fill_chk.sv
`timescale 1ns/1ps
// cm_block_fill_chk: protocol checks on the initialiser's ports, bound to the top.
module cm_block_fill_chk #(
    parameter int unsigned DEPTH        = 1024,
    parameter int unsigned FRAME_CYCLES = 2048,
    localparam int unsigned AW          = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode_en,
    input logic          rd_slot,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [11:0]   low_bits,
    input logic          fill_busy
);
    logic [AW-1:0] exp_addr;
    logic [31:0]   busy_cycles;

    // Expected next fill address, counted from observed fill writes.
    always_ff @(posedge clk) begin
        if (!rst_n || !fill_busy) exp_addr <= '0;
        else if (mem_we)          exp_addr <= exp_addr + 1'b1;
    end

    // Length of the current sweep in cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !fill_busy) busy_cycles <= '0;
        else                      busy_cycles <= busy_cycles + 1;
    end

    // R7
    no_write_in_read_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_slot |-> !mem_we);

    // R5
    fill_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_busy && mem_we) |-> (low_bits == 12'h000));

    // R4
    fill_addr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_busy && mem_we) |-> (mem_addr == exp_addr));

    // R2
    disarmed_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> !fill_busy);

    // R6
    busy_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fill_busy) |-> ($past(mem_we && mem_addr == AW'(DEPTH - 1)) || !$past(mode_en)));

    // R11
    two_frame_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_busy |-> (busy_cycles < 2 * FRAME_CYCLES));
endmodule

bind cm_block_fill cm_block_fill_chk #(.DEPTH(DEPTH)) i_cm_block_fill_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_en   (mode_en),
    .rd_slot   (rd_slot),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .low_bits  (mem_wdata[11:0]),
    .fill_busy (fill_busy)
);

// File: tb/test_cm_block_fill.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task pushes one expected port item per cycle,
// and the monitor pops it and compares it with the design's outputs.
module test_cm_block_fill;
    localparam int unsigned DEPTH = 1024;
    localparam int unsigned FRAME = 2048;
    localparam int unsigned AW    = $clog2(DEPTH);

    typedef struct {
        logic          busy;
        logic          we;
        logic [AW-1:0] addr;
        logic [15:0]   data;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_en = 1'b0;
    logic          trig_set = 1'b0;
    logic [3:0]    fill_pat = '0;
    logic          rd_slot = 1'b0;
    logic          cpu_wr = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [15:0]   cpu_wdata = '0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic          fill_busy;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    item_t q[$];

    // Reference state derived from the requirements.
    logic          m_busy = 0;
    logic [AW-1:0] m_ptr = '0;
    logic [3:0]    m_pat = '0;
    int            m_run = 0;

    always #2 clk = ~clk;

    cm_block_fill i_cm_block_fill (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .trig_set(trig_set),
        .fill_pat(fill_pat), .rd_slot(rd_slot), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .fill_busy(fill_busy)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and pushes the expected port state.
    task automatic step(input logic rd, input logic cw, input logic [AW-1:0] ca,
                        input logic [15:0] cd, input logic ts, input logic me,
                        input logic [3:0] p, input string tag);
        item_t e;
        @(negedge clk);
        rd_slot = rd; cpu_wr = cw; cpu_addr = ca; cpu_wdata = cd;
        trig_set = ts; mode_en = me; fill_pat = p;
        e.busy = m_busy; e.tag = tag;
        if (m_busy) begin
            e.we = me && !rd; e.addr = m_ptr; e.data = {m_pat, 12'h000};
        end else begin
            e.we = cw && !rd; e.addr = ca; e.data = cd;
        end
        q.push_back(e);
        if (m_busy) m_run++;
        if (!me) begin
            m_busy = 0; m_ptr = '0;
        end else if (m_busy) begin
            if (!rd) begin
                if (m_ptr == AW'(DEPTH - 1)) begin
                    m_busy = 0; m_ptr = '0;
                end else m_ptr = m_ptr + 1'b1;
            end
        end else if (ts) begin
            m_busy = 1; m_ptr = '0; m_pat = p; m_run = 0;
        end
    endtask

    // Monitor: compares each cycle's outputs with the queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                item_t e;
                e = q.pop_front();
                checks++;
                if (fill_busy !== e.busy || mem_we !== e.we ||
                    (e.we && (mem_addr !== e.addr || mem_wdata !== e.data))) begin
                    failures++;
                    $display("FAIL %s: busy=%0b we=%0b addr=%0d data=%h expected busy=%0b we=%0b addr=%0d data=%h",
                             e.tag, fill_busy, mem_we, mem_addr, mem_wdata,
                             e.busy, e.we, e.addr, e.data);
                end
            end
        end
    end

    // Runs a full sweep. rdm selects the read-slot pattern: 0 none, 1 alternate, 2 every third.
    task automatic sweep(input logic [3:0] p, input int rdm, input string tag);
        int n = 0;
        step(1'b0, 1'b0, '0, '0, 1'b1, 1'b1, p, {tag, " R3 start"});
        while (m_busy && n < 4 * DEPTH) begin
            logic rd;
            rd = (rdm == 1) ? logic'(n % 2 == 0) : (rdm == 2) ? logic'(n % 3 == 0) : 1'b0;
            // R8: processor writes and stray triggers during the sweep; R5: live pattern changes
            step(rd, logic'(n % 5 == 1), AW'(n * 7), 16'hBEEF, logic'(n == 9), 1'b1,
                 p ^ 4'hF, {tag, " R4 R5 R7 R8"});
            n++;
        end
        // R11: the sweep must finish within two frames
        check({tag, " R11 sweep length"}, m_run, (m_run <= 2 * FRAME) ? m_run : 2 * FRAME);
        step(1'b0, 1'b0, '0, '0, 1'b0, 1'b1, p, {tag, " R6 trigger cleared"});
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with a trigger attempted while in reset
        repeat (3) @(negedge clk);
        mode_en = 1'b1; trig_set = 1'b1;
        @(negedge clk);
        #1;
        check("R1 busy in reset", fill_busy, 0);
        check("R1 we in reset", mem_we, 0);
        mode_en = 1'b0; trig_set = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1 busy after reset", fill_busy, 0);
        check("R1 we after reset", mem_we, 0);

        // R2: trigger ignored while disarmed; R9: idle processor writes pass through
        for (int i = 0; i < 6; i++)
            step(logic'(i == 3), 1'b1, AW'(100 + i), 16'h1230 + 16'(i), 1'b1, 1'b0,
                 4'h3, "R2 R9 disarmed trigger");

        // R3 R4 R5 R6: sweep with no read slots
        sweep(4'hA, 0, "plain");
        // R7 R11: worst-case alternating read slots
        sweep(4'h5, 1, "alternate");
        // Read slots on every third cycle
        sweep(4'hC, 2, "third");

        // R10: abort mid-sweep, then restart from address 0
        step(1'b0, 1'b0, '0, '0, 1'b1, 1'b1, 4'h7, "R10 start");
        for (int i = 0; i < 100; i++)
            step(logic'(i % 2), 1'b0, '0, '0, 1'b0, 1'b1, 4'h7, "R10 running");
        step(1'b0, 1'b1, AW'(5), 16'h5555, 1'b0, 1'b0, 4'h7, "R10 abort cycle");
        for (int i = 0; i < 4; i++)
            step(1'b0, 1'b1, AW'(20 + i), 16'h0F00, 1'b0, 1'b0, 4'h7, "R10 R9 after abort");
        sweep(4'h9, 0, "R10 restart");

        repeat (3) @(negedge clk);
        check("R4 scoreboard drained", q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule